// File: doc/BRIEF.md
# Bit-Band Alias Bus Bridge

This block sits between a processor load/store port and a word-wide memory or peripheral port. Most accesses pass straight through. Two address windows are treated as bit aliases: each 32-bit word in an alias window stands for one bit of a byte in a matching bit region. One window pair covers SRAM and the other covers peripherals. A store to an alias word becomes a locked read-modify-write on the aligned target word, and that write changes exactly one bit. A load from an alias word returns that bit in bit 0.

Each side uses a valid/ready request handshake. The processor side accepts one request at a time and signals completion with a one-cycle response pulse. The memory side returns read data with a one-cycle data strobe, and that strobe may arrive any number of cycles after the request was accepted. No other memory access can come between the read and the write of a read-modify-write, so the single-bit update is atomic for the processor.

Top module: `bitband_bridge`

## Requirements
- R1: A request whose address lies outside both alias windows is forwarded once, with its write flag, address, size, byte strobes and store data unchanged. A load returns the memory word unchanged. A store completes with response data 0.
- R2: SRAM alias window. Addresses 0x22000000 to 0x23FFFFFF select a bit in the region 0x20000000 to 0x200FFFFF. With alias offset o = address − 0x22000000, the target byte is 0x20000000 + o[24:5] and the bit inside that byte is o[4:2]. For example, 0x22080000 selects bit 0 of 0x20004000, and 0x2208001C selects bit 7 of the same byte.
- R3: Peripheral alias window. Addresses 0x42000000 to 0x43FFFFFF map the same way onto the region 0x40000000 to 0x400FFFFF. For example, 0x42080000 selects bit 0 of 0x40004000.
- R4: An alias store issues two memory requests. The first reads the target word: the target byte address with bits [1:0] cleared, size word, strobes 4'b1111. The second writes that same word address, with size word and strobes 4'b1111. The written data equals the read data except at bit position (target byte address mod 4)·8 + bit-in-byte.
- R5: The new value of the target bit is bit 0 of the store data (1 sets it, 0 clears it). Store data bits [31:1] have no effect.
- R6: An alias load issues exactly one memory read, of the aligned target word, with no write. Its response data holds the target bit in bit 0, and bits [31:1] are 0.
- R7: Byte-size (cpu_size 2'b00) and word-size (cpu_size 2'b10) alias accesses act identically on the same bit. On the memory side, alias accesses always use word size (2'b10). Size code 2'b01 is a halfword and is only ever forwarded.
- R8: cpu_ready is high only while the bridge is idle. After a request is accepted, cpu_ready stays low until the one-cycle cpu_rsp_valid pulse. No memory request is raised while the bridge is idle. In a read-modify-write, the write request follows the read data with no other request between them.
- R9: After reset, cpu_ready is 1 and both mem_valid and cpu_rsp_valid are 0.
- R10: Once raised, mem_valid stays high with a stable address and write flag until mem_ready is seen.
- R11: Addresses just outside the alias windows (0x21FFFFFC, 0x24000000, 0x41FFFFFC, 0x44000000) and addresses inside the bit regions themselves are forwarded as in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor request valid |
| cpu_ready | output | 1 | Bridge idle and able to accept a request |
| cpu_write | input | 1 | 1 = store, 0 = load |
| cpu_size | input | 2 | 00 byte, 01 halfword, 10 word |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_wstrb | input | 4 | Byte strobes of the store |
| cpu_rsp_valid | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Load result, valid with cpu_rsp_valid |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts the request |
| mem_write | output | 1 | Memory request is a write |
| mem_size | output | 2 | Memory access size, same coding as cpu_size |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_wstrb | output | 4 | Memory byte strobes |
| mem_rvalid | input | 1 | Read data strobe |
| mem_rdata | input | 32 | Read data word |

## Verification
The bench builds the bridge with its default parameters: two window pairs at the SRAM and peripheral bases, with 1 MB bit regions and therefore 32 MB alias windows. With these values the edges of each alias window are within reach: the first and last alias words, and the words immediately before and after each window. Accesses to both windows are mixed with pass-through traffic. The memory model adds varying ready and read-data delays, so that the held request and the atomic read-then-write ordering are exercised under stall.

// File: rtl/bb_pkg.sv
package bb_pkg;

  localparam int BB_AW    = 32;
  localparam int BB_DW    = 32;
  localparam int BB_SW    = BB_DW / 8;
  localparam int BB_POS_W = $clog2(BB_DW);

  localparam logic [1:0] BB_SIZE_WORD = 2'b10;
  localparam logic [BB_SW-1:0] BB_STRB_ALL = '1;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_ISSUE,
    SQ_WAIT_RD,
    SQ_WR_ISSUE,
    SQ_RESP
  } bb_state_e;

  // Word holding a given byte address.
  function automatic logic [BB_AW-1:0] bb_word_align(input logic [BB_AW-1:0] a);
    return {a[BB_AW-1:2], 2'b00};
  endfunction

  // Position of a bit in the word: byte lane * 8 + bit-in-byte.
  function automatic logic [BB_POS_W-1:0] bb_bit_pos(input logic [1:0] lane,
                                                     input logic [2:0] bit_in_byte);
    return {lane, bit_in_byte};
  endfunction

endpackage

// File: rtl/bb_alias_decode.sv
module bb_alias_decode
  import bb_pkg::*;
#(
  parameter int NUM_WIN     = 2,
  parameter int REGION_BITS = 20,
  parameter logic [NUM_WIN-1:0][BB_AW-1:0] REGION_BASE = '0,
  parameter logic [NUM_WIN-1:0][BB_AW-1:0] ALIAS_BASE  = '0
) (
  input  logic [BB_AW-1:2]    addr_hi,
  output logic                alias_hit,
  output logic [BB_AW-1:0]    target_word,
  output logic [BB_POS_W-1:0] target_pos
);

  localparam int ALIAS_BITS = REGION_BITS + 5;

  logic [NUM_WIN-1:0] hit_vec;
  logic [BB_AW-1:0]    word_vec [NUM_WIN];
  logic [BB_POS_W-1:0] pos_vec  [NUM_WIN];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic [REGION_BITS-1:0] byte_off;
    logic [BB_AW-1:0]       tgt_byte;

    assign hit_vec[w] = (addr_hi[BB_AW-1:ALIAS_BITS] ==
                         ALIAS_BASE[w][BB_AW-1:ALIAS_BITS]);
    assign byte_off   = addr_hi[ALIAS_BITS-1:5];
    assign tgt_byte   = REGION_BASE[w] + BB_AW'(byte_off);
    assign word_vec[w] = bb_word_align(tgt_byte);
    assign pos_vec[w]  = bb_bit_pos(tgt_byte[1:0], addr_hi[4:2]);
  end

  // Lowest window index wins if windows are ever configured to overlap.
  always_comb begin
    alias_hit   = 1'b0;
    target_word = '0;
    target_pos  = '0;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (hit_vec[w]) begin
        alias_hit   = 1'b1;
        target_word = word_vec[w];
        target_pos  = pos_vec[w];
      end
    end
  end

endmodule

// File: rtl/bb_bit_merge.sv
module bb_bit_merge
  import bb_pkg::*;
(
  input  logic [BB_DW-1:0]    old_word,
  input  logic [BB_POS_W-1:0] pos,
  input  logic                new_bit,
  output logic [BB_DW-1:0]    merged_word,
  output logic                picked_bit
);

  for (genvar i = 0; i < BB_DW; i++) begin : g_bit
    assign merged_word[i] = (pos == BB_POS_W'(i)) ? new_bit : old_word[i];
  end

  assign picked_bit = old_word[pos];

endmodule

// File: rtl/bb_sequencer.sv
module bb_sequencer
  import bb_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cpu_valid,
  output logic                cpu_ready,
  input  logic                cpu_write,
  input  logic [1:0]          cpu_size,
  input  logic [BB_AW-1:0]    cpu_addr,
  input  logic [BB_DW-1:0]    cpu_wdata,
  input  logic [BB_SW-1:0]    cpu_wstrb,
  output logic                cpu_rsp_valid,
  output logic [BB_DW-1:0]    cpu_rdata,
  input  logic                dec_hit,
  input  logic [BB_AW-1:0]    dec_word,
  input  logic [BB_POS_W-1:0] dec_pos,
  output logic [BB_DW-1:0]    rd_word,
  output logic [BB_POS_W-1:0] bit_pos,
  output logic                new_bit,
  input  logic [BB_DW-1:0]    merged_word,
  input  logic                picked_bit,
  output logic                mem_valid,
  input  logic                mem_ready,
  output logic                mem_write,
  output logic [1:0]          mem_size,
  output logic [BB_AW-1:0]    mem_addr,
  output logic [BB_DW-1:0]    mem_wdata,
  output logic [BB_SW-1:0]    mem_wstrb,
  input  logic                mem_rvalid,
  input  logic [BB_DW-1:0]    mem_rdata
);

  bb_state_e state_q;
  logic                wr_q, alias_q, newbit_q;
  logic [1:0]          size_q;
  logic [BB_AW-1:0]    addr_q;
  logic [BB_DW-1:0]    wdata_q, rdata_q, rmw_old_q;
  logic [BB_SW-1:0]    strb_q;
  logic [BB_POS_W-1:0] pos_q;

  // Named events for the assertions.
  logic accept_ev, rmw_read_done, rmw_write_phase, alias_load_busy;
  assign accept_ev       = cpu_valid && cpu_ready;
  assign rmw_read_done   = (state_q == SQ_WAIT_RD) && alias_q && wr_q && mem_rvalid;
  assign rmw_write_phase = (state_q == SQ_WR_ISSUE);
  assign alias_load_busy = alias_q && !wr_q && (state_q != SQ_IDLE);

  assign rd_word = mem_rdata;
  assign bit_pos = pos_q;
  assign new_bit = newbit_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= SQ_IDLE;
      wr_q      <= 1'b0;
      alias_q   <= 1'b0;
      newbit_q  <= 1'b0;
      size_q    <= '0;
      addr_q    <= '0;
      wdata_q   <= '0;
      rdata_q   <= '0;
      rmw_old_q <= '0;
      strb_q    <= '0;
      pos_q     <= '0;
    end else begin
      case (state_q)
        SQ_IDLE: begin
          if (cpu_valid) begin
            wr_q     <= cpu_write;
            alias_q  <= dec_hit;
            addr_q   <= dec_hit ? dec_word : cpu_addr;
            size_q   <= dec_hit ? BB_SIZE_WORD : cpu_size;
            strb_q   <= dec_hit ? BB_STRB_ALL : cpu_wstrb;
            wdata_q  <= cpu_wdata;
            newbit_q <= cpu_wdata[0];
            pos_q    <= dec_pos;
            state_q  <= SQ_ISSUE;
          end
        end
        SQ_ISSUE: begin
          if (mem_ready) begin
            if (wr_q && !alias_q) begin
              rdata_q <= '0;
              state_q <= SQ_RESP;
            end else begin
              state_q <= SQ_WAIT_RD;
            end
          end
        end
        SQ_WAIT_RD: begin
          if (mem_rvalid) begin
            if (!alias_q) begin
              rdata_q <= mem_rdata;
              state_q <= SQ_RESP;
            end else if (!wr_q) begin
              rdata_q <= {{(BB_DW-1){1'b0}}, picked_bit};
              state_q <= SQ_RESP;
            end else begin
              rmw_old_q <= mem_rdata;
              wdata_q   <= merged_word;
              rdata_q   <= '0;
              state_q   <= SQ_WR_ISSUE;
            end
          end
        end
        SQ_WR_ISSUE: begin
          if (mem_ready) state_q <= SQ_RESP;
        end
        SQ_RESP: state_q <= SQ_IDLE;
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign cpu_ready     = (state_q == SQ_IDLE);
  assign cpu_rsp_valid = (state_q == SQ_RESP);
  assign cpu_rdata     = rdata_q;

  assign mem_valid = (state_q == SQ_ISSUE) || (state_q == SQ_WR_ISSUE);
  assign mem_write = (state_q == SQ_WR_ISSUE) || (wr_q && !alias_q);
  assign mem_size  = size_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
  assign mem_wstrb = strb_q;

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_write)); // R10

  AST_CPU_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ev |=> !cpu_ready); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> !mem_valid); // R8

  AST_RMW_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    rmw_read_done |=> mem_valid && mem_write && mem_addr == $past(mem_addr)); // R8

  AST_RMW_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    rmw_write_phase |-> $countones(mem_wdata ^ rmw_old_q) <= 1); // R4

  AST_RMW_FULL_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    rmw_write_phase |-> mem_wstrb == BB_STRB_ALL && mem_size == BB_SIZE_WORD); // R4

  AST_RMW_BIT_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    rmw_write_phase |-> mem_wdata[pos_q] == newbit_q); // R5

  AST_LOAD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    alias_load_busy |-> !(mem_valid && mem_write)); // R6

  AST_LOAD_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid && alias_q && !wr_q |-> cpu_rdata[BB_DW-1:1] == '0); // R6

endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
  import bb_pkg::*;
#(
  parameter logic [31:0] SRAM_REGION = 32'h2000_0000,
  parameter logic [31:0] SRAM_ALIAS  = 32'h2200_0000,
  parameter logic [31:0] PERI_REGION = 32'h4000_0000,
  parameter logic [31:0] PERI_ALIAS  = 32'h4200_0000,
  parameter int          REGION_BITS = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_valid,
  output logic        cpu_ready,
  input  logic        cpu_write,
  input  logic [1:0]  cpu_size,
  input  logic [31:0] cpu_addr,
  input  logic [31:0] cpu_wdata,
  input  logic [3:0]  cpu_wstrb,
  output logic        cpu_rsp_valid,
  output logic [31:0] cpu_rdata,
  output logic        mem_valid,
  input  logic        mem_ready,
  output logic        mem_write,
  output logic [1:0]  mem_size,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic [3:0]  mem_wstrb,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata
);

  localparam int NUM_WIN = 2;
  localparam logic [NUM_WIN-1:0][BB_AW-1:0] REGION_TAB = {PERI_REGION, SRAM_REGION};
  localparam logic [NUM_WIN-1:0][BB_AW-1:0] ALIAS_TAB  = {PERI_ALIAS,  SRAM_ALIAS};

  logic                dec_hit;
  logic [BB_AW-1:0]    dec_word;
  logic [BB_POS_W-1:0] dec_pos;
  logic [BB_DW-1:0]    rd_word, merged_word;
  logic [BB_POS_W-1:0] bit_pos;
  logic                new_bit, picked_bit;

  bb_alias_decode #(
    .NUM_WIN     (NUM_WIN),
    .REGION_BITS (REGION_BITS),
    .REGION_BASE (REGION_TAB),
    .ALIAS_BASE  (ALIAS_TAB)
  ) u_decode (
    .addr_hi     (cpu_addr[BB_AW-1:2]),
    .alias_hit   (dec_hit),
    .target_word (dec_word),
    .target_pos  (dec_pos)
  );

  bb_bit_merge u_merge (
    .old_word    (rd_word),
    .pos         (bit_pos),
    .new_bit     (new_bit),
    .merged_word (merged_word),
    .picked_bit  (picked_bit)
  );

  bb_sequencer u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_valid     (cpu_valid),
    .cpu_ready     (cpu_ready),
    .cpu_write     (cpu_write),
    .cpu_size      (cpu_size),
    .cpu_addr      (cpu_addr),
    .cpu_wdata     (cpu_wdata),
    .cpu_wstrb     (cpu_wstrb),
    .cpu_rsp_valid (cpu_rsp_valid),
    .cpu_rdata     (cpu_rdata),
    .dec_hit       (dec_hit),
    .dec_word      (dec_word),
    .dec_pos       (dec_pos),
    .rd_word       (rd_word),
    .bit_pos       (bit_pos),
    .new_bit       (new_bit),
    .merged_word   (merged_word),
    .picked_bit    (picked_bit),
    .mem_valid     (mem_valid),
    .mem_ready     (mem_ready),
    .mem_write     (mem_write),
    .mem_size      (mem_size),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .mem_wstrb     (mem_wstrb),
    .mem_rvalid    (mem_rvalid),
    .mem_rdata     (mem_rdata)
  );

endmodule

// File: tb/bitband_bridge_tb_top.sv
module bitband_bridge_tb_top;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic        cpu_valid, cpu_ready, cpu_write, cpu_rsp_valid;
  logic [1:0]  cpu_size;
  logic [31:0] cpu_addr, cpu_wdata, cpu_rdata;
  logic [3:0]  cpu_wstrb;
  logic        mem_valid, mem_ready, mem_write, mem_rvalid;
  logic [1:0]  mem_size;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_wstrb;

  bitband_bridge dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_write(cpu_write),
    .cpu_size(cpu_size), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wstrb(cpu_wstrb), .cpu_rsp_valid(cpu_rsp_valid), .cpu_rdata(cpu_rdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_size(mem_size), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_wstrb(mem_wstrb), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;
  bit op_busy = 0;
  bit load_busy = 0;

  typedef struct {
    bit          wr;
    logic [31:0] addr;
    logic [1:0]  size;
    logic [31:0] data;
    logic [3:0]  strb;
  } acc_t;

  acc_t seen_q[$];
  acc_t exp_q[$];
  logic [31:0] mem_words [bit [31:0]];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] peek(input logic [31:0] a);
    logic [31:0] w = {a[31:2], 2'b00};
    if (mem_words.exists(w)) return mem_words[w];
    return w ^ 32'h5A3C_96E1;
  endfunction

  function automatic logic [15:0] step(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  // Memory slave: decides ready and read data at the falling edge.
  logic [15:0] slv_lfsr = 16'hACE1;
  initial begin
    int gap = 0;
    int rd_wait = 0;
    bit rd_pending = 0;
    logic [31:0] rd_word = '0;
    mem_ready = 0; mem_rvalid = 0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      mem_rvalid = 0;
      mem_ready  = 0;
      slv_lfsr   = step(slv_lfsr);
      if (rd_pending) begin
        if (rd_wait == 0) begin
          mem_rvalid = 1; mem_rdata = rd_word; rd_pending = 0;
        end else rd_wait--;
      end else if (mem_valid && rst_n) begin
        if (gap == 0) begin
          acc_t a;
          mem_ready = 1;
          a.wr = mem_write; a.addr = mem_addr; a.size = mem_size;
          a.data = mem_wdata; a.strb = mem_wstrb;
          seen_q.push_back(a);
          if (mem_write) begin
            logic [31:0] w = peek(mem_addr);
            for (int k = 0; k < 4; k++)
              if (mem_wstrb[k]) w[8*k +: 8] = mem_wdata[8*k +: 8];
            mem_words[{mem_addr[31:2], 2'b00}] = w;
          end else begin
            rd_pending = 1; rd_word = peek(mem_addr); rd_wait = int'(slv_lfsr[1:0]) % 3;
          end
          gap = int'(slv_lfsr[3:2]) % 3;
        end else gap--;
      end
    end
  end

  // Per-cycle comparison against the bench's own phase tracking.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && !done) begin
        if (!op_busy)
          check(mem_valid == 1'b0, "R8", "memory request while idle", 32'(mem_valid), 32'd0);
        if (!op_busy)
          check(cpu_ready == 1'b1, "R8", "ready while idle", 32'(cpu_ready), 32'd1);
        if (load_busy)
          check(!(mem_valid && mem_write), "R6", "write during alias load",
                32'(mem_valid && mem_write), 32'd0);
      end
    end
  end

  task automatic run_op(input bit wr, input logic [1:0] size, input logic [31:0] addr,
                        input logic [31:0] wdata, input logic [3:0] strb,
                        output logic [31:0] rdata);
    int guard = 0;
    @(negedge clk);
    op_busy = 1;
    seen_q.delete();
    cpu_valid = 1; cpu_write = wr; cpu_size = size; cpu_addr = addr;
    cpu_wdata = wdata; cpu_wstrb = strb;
    while (!cpu_ready) @(negedge clk);
    @(negedge clk);
    cpu_valid = 0;
    check(cpu_ready == 1'b0, "R8", "ready after accept", 32'(cpu_ready), 32'd0);
    while (!cpu_rsp_valid && guard < 100) begin
      @(negedge clk);
      if (!cpu_rsp_valid)
        check(cpu_ready == 1'b0, "R8", "ready while busy", 32'(cpu_ready), 32'd0);
      guard++;
    end
    rdata = cpu_rdata;
    op_busy = 0;
    load_busy = 0;
  endtask

  task automatic compare_access(input string req);
    check(seen_q.size() == exp_q.size(), req, "access count", seen_q.size(), exp_q.size());
    if (seen_q.size() == exp_q.size()) begin
      foreach (exp_q[i]) begin
        check(seen_q[i].wr == exp_q[i].wr, req, "write flag", 32'(seen_q[i].wr), 32'(exp_q[i].wr));
        check(seen_q[i].addr == exp_q[i].addr, req, "address", seen_q[i].addr, exp_q[i].addr);
        check(seen_q[i].size == exp_q[i].size, req, "size", 32'(seen_q[i].size), 32'(exp_q[i].size));
        check(seen_q[i].strb == exp_q[i].strb, req, "strobes", 32'(seen_q[i].strb), 32'(exp_q[i].strb));
        if (exp_q[i].wr)
          check(seen_q[i].data == exp_q[i].data, req, "write data", seen_q[i].data, exp_q[i].data);
      end
    end
    exp_q.delete();
  endtask

  task automatic pass_op(input bit wr, input logic [1:0] size, input logic [31:0] addr,
                         input logic [31:0] data, input logic [3:0] strb, input string req);
    acc_t a;
    logic [31:0] exp_r, got;
    exp_r = wr ? 32'd0 : peek(addr);
    a.wr = wr; a.addr = addr; a.size = size; a.data = data; a.strb = strb;
    exp_q.push_back(a);
    run_op(wr, size, addr, data, strb, got);
    check(got == exp_r, req, "response data", got, exp_r);
    compare_access(req);
  endtask

  // Alias access with explicit alias address and expected target.
  task automatic alias_raw(input bit wr, input logic [1:0] size, input logic [31:0] aa,
                           input logic [31:0] tbyte, input int b, input logic [31:0] data,
                           input string req);
    acc_t a;
    logic [31:0] tw, old, nw, exp_r, got;
    int pos;
    tw  = tbyte & 32'hFFFF_FFFC;
    pos = int'(tbyte % 4) * 8 + b;
    old = peek(tw);
    nw  = old;
    nw[pos] = data[0];
    a.wr = 0; a.addr = tw; a.size = 2'b10; a.data = '0; a.strb = 4'hF;
    exp_q.push_back(a);
    if (wr) begin
      a.wr = 1; a.data = nw;
      exp_q.push_back(a);
      exp_r = 32'd0;
    end else exp_r = 32'(old[pos]);
    load_busy = !wr;
    run_op(wr, size, aa, data, (size == 2'b10) ? 4'hF : (4'b0001 << aa[1:0]), got);
    check(got == exp_r, req, "response data", got, exp_r);
    compare_access(req);
  endtask

  function automatic logic [31:0] alias_of(input logic [31:0] rbase, input logic [31:0] abase,
                                           input logic [31:0] a, input int b);
    return abase + ((a - rbase) * 32) + 32'(b * 4);
  endfunction

  initial begin
    logic [15:0] r = 16'h1D0F;
    logic [31:0] dummy;
    cpu_valid = 0; cpu_write = 0; cpu_size = 0; cpu_addr = 0; cpu_wdata = 0; cpu_wstrb = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    check(cpu_ready == 1'b1, "R9", "reset ready", 32'(cpu_ready), 32'd1);
    check(mem_valid == 1'b0, "R9", "reset mem_valid", 32'(mem_valid), 32'd0);
    check(cpu_rsp_valid == 1'b0, "R9", "reset rsp", 32'(cpu_rsp_valid), 32'd0);
    rst_n = 1;
    @(negedge clk);

    // R1: plain traffic, including the bit region itself.
    pass_op(1, 2'b10, 32'h2000_4000, 32'h1234_5670, 4'hF, "R1");
    pass_op(0, 2'b10, 32'h2000_4000, 32'h0, 4'h0, "R1");
    pass_op(1, 2'b00, 32'h3000_0001, 32'hDEAD_BEEF, 4'b0010, "R1");
    pass_op(1, 2'b01, 32'h1000_0002, 32'hCAFE_F00D, 4'b1100, "R1");
    pass_op(0, 2'b00, 32'h3000_0001, 32'h0, 4'h0, "R1");

    // R2: literal SRAM mapping points.
    check(alias_of(32'h2000_0000, 32'h2200_0000, 32'h2000_4000, 0) == 32'h2208_0000,
          "R2", "bench alias formula", alias_of(32'h2000_0000, 32'h2200_0000, 32'h2000_4000, 0),
          32'h2208_0000);
    alias_raw(1, 2'b10, 32'h2208_0000, 32'h2000_4000, 0, 32'h1, "R2");
    alias_raw(0, 2'b10, 32'h2208_0000, 32'h2000_4000, 0, 32'h0, "R2");
    alias_raw(0, 2'b10, 32'h2208_001C, 32'h2000_4000, 7, 32'h0, "R6");
    alias_raw(1, 2'b10, 32'h2208_001C, 32'h2000_4000, 7, 32'h1, "R4");
    alias_raw(0, 2'b10, 32'h2208_001C, 32'h2000_4000, 7, 32'h0, "R6");

    // R3: peripheral window.
    alias_raw(1, 2'b10, 32'h4208_0000, 32'h4000_4000, 0, 32'h1, "R3");
    alias_raw(0, 2'b00, 32'h4208_0000, 32'h4000_4000, 0, 32'h0, "R3");
    alias_raw(1, 2'b10, 32'h4208_0060, 32'h4000_4003, 0, 32'h0, "R3");

    // R5: only data bit 0 matters.
    alias_raw(1, 2'b10, alias_of(32'h2000_0000, 32'h2200_0000, 32'h2000_0105, 3), 32'h2000_0105, 3,
              32'hFFFF_FFFE, "R5");
    alias_raw(0, 2'b10, alias_of(32'h2000_0000, 32'h2200_0000, 32'h2000_0105, 3), 32'h2000_0105, 3,
              32'h0, "R5");
    alias_raw(1, 2'b10, alias_of(32'h2000_0000, 32'h2200_0000, 32'h2000_0105, 3), 32'h2000_0105, 3,
              32'h0000_0001, "R5");
    alias_raw(0, 2'b10, alias_of(32'h2000_0000, 32'h2200_0000, 32'h2000_0105, 3), 32'h2000_0105, 3,
              32'h0, "R5");

    // R7: byte size acts like word size.
    alias_raw(1, 2'b00, alias_of(32'h2000_0000, 32'h2200_0000, 32'h2000_0203, 5), 32'h2000_0203, 5,
              32'h1, "R7");
    alias_raw(0, 2'b00, alias_of(32'h2000_0000, 32'h2200_0000, 32'h2000_0203, 5), 32'h2000_0203, 5,
              32'h0, "R7");
    alias_raw(1, 2'b00, alias_of(32'h2000_0000, 32'h2200_0000, 32'h2000_0203, 5), 32'h2000_0203, 5,
              32'h0, "R7");
    alias_raw(0, 2'b10, alias_of(32'h2000_0000, 32'h2200_0000, 32'h2000_0203, 5), 32'h2000_0203, 5,
              32'h0, "R7");

    // Window edges: last alias words map to the last region byte.
    alias_raw(1, 2'b10, 32'h23FF_FFFC, 32'h200F_FFFF, 7, 32'h1, "R2");
    alias_raw(1, 2'b10, 32'h43FF_FFFC, 32'h400F_FFFF, 7, 32'h0, "R3");
    alias_raw(0, 2'b10, 32'h2200_0000, 32'h2000_0000, 0, 32'h0, "R2");

    // R11: just outside the windows.
    pass_op(1, 2'b10, 32'h21FF_FFFC, 32'h0BAD_CAFE, 4'hF, "R11");
    pass_op(0, 2'b10, 32'h2400_0000, 32'h0, 4'h0, "R11");
    pass_op(1, 2'b10, 32'h41FF_FFFC, 32'h7777_1111, 4'h3, "R11");
    pass_op(0, 2'b10, 32'h4400_0000, 32'h0, 4'h0, "R11");
    pass_op(0, 2'b10, 32'h400F_FFFC, 32'h0, 4'h0, "R11");

    // Mixed traffic across both windows.
    for (int n = 0; n < 300; n++) begin
      logic [31:0] rb, ab, tb;
      int bb;
      r = step(r); r = step(r);
      rb = r[0] ? 32'h4000_0000 : 32'h2000_0000;
      ab = r[0] ? 32'h4200_0000 : 32'h2200_0000;
      tb = rb + {24'd0, r[15:8]} + {12'd0, r[7:4], 16'd0};
      bb = int'(r[3:1]);
      if (r[15:13] == 3'b000)
        pass_op(r[5], 2'b10, 32'h3000_0000 + {16'd0, r[11:0], 4'd0}, {r, ~r}, 4'hF, "R1");
      else
        alias_raw(r[2], r[9] ? 2'b10 : 2'b00, alias_of(rb, ab, tb, bb), tb, bb,
                  {~r, r[12:0], r[4:2]}, r[2] ? "R4" : "R6");
    end
    run_op(0, 2'b10, 32'h2000_0000, 0, 0, dummy);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule